// File: doc/BRIEF.md
# Compare-Match Watchdog Interval Timer

This block watches for a stalled processor. A 7-bit up-counter advances once per tick of a chosen count source, and on every counted tick it is compared with a programmable 7-bit limit. When the count equals the limit on a tick, the counter wraps to zero on that same tick and the block acts. A mode input decides the action. It can pulse a processor reset request, or it can set a sticky interrupt flag. The second choice lets the same hardware serve as a plain periodic interval timer, with a period of (limit + 1) ticks.

Software writes one 8-bit control word. The low seven bits load the limit. The top bit is a restart command that zeroes the counter and then drops by itself. Two count sources are available. The primary source is an overflow pulse from a preceding interval timer that runs in the block's own clock domain. The primary ticks are counted only after that timer has reported a clear once. The alternate source is a free-running tick from an independent oscillator. It is brought into the clock domain through a synchroniser and an edge detector, so every rising edge of it is counted once.

Top module: `cmp_watchdog`

## Requirements
- R1: While `rst` is high, and at the first sample after it falls, `count` is 0, `irq_flag` is 0, `cpu_rst_req` is 0. The limit resets to 127 and the primary source starts unarmed.
- R2: A pulse on `base_tick` is ignored until a cycle with `base_clr` high has been seen. A `base_tick` in that same cycle is still ignored. After it, every `base_tick` cycle is a primary tick.
- R3: `sel_alt` = 0 selects the primary ticks and `sel_alt` = 1 selects the alternate ticks. Each selected tick raises `count` by one at the clock edge that samples it. Ticks from the unselected source leave `count` unchanged.
- R4: When a selected tick arrives while `count` equals the limit, `count` becomes 0 at that edge, and a match is reported at that same edge. With ticks every cycle and a limit N, matches repeat every N+1 ticks.
- R5: With `act_reset` = 0, a match sets `irq_flag` at the matching edge. The flag stays set until a cycle with `irq_clr` high. A match and a clear in the same cycle leave the flag set. `cpu_rst_req` stays 0.
- R6: With `act_reset` = 1, a match drives `cpu_rst_req` high for the single cycle after the matching edge. `irq_flag` is not set.
- R7: A cycle with `wr_en` high loads `wr_data[6:0]` as the limit. If `wr_data[7]` is 1, `count` is 0 after the next edge. A tick in that following cycle is discarded and reports no match, and the restart bit then drops by itself.
- R8: Each rising edge of the asynchronous `alt_tick` input, held high and then low for at least two clock cycles each, advances `count` by exactly one. The count appears by the third clock edge after the rise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 8 | Control word: [7] restart, [6:0] limit |
| act_reset | input | 1 | Match action: 1 reset request, 0 interrupt flag |
| base_tick | input | 1 | Primary tick: one-cycle overflow pulse of the interval timer |
| base_clr | input | 1 | Interval-timer cleared indication; arms the primary source |
| alt_tick | input | 1 | Asynchronous alternate tick from the independent oscillator |
| sel_alt | input | 1 | Count-source select: 1 alternate, 0 primary |
| irq_clr | input | 1 | Clears the interrupt flag |
| irq_flag | output | 1 | Sticky interrupt flag |
| cpu_rst_req | output | 1 | One-cycle reset request |
| count | output | 7 | Current counter value |

## Verification
The hardest case to produce is a restart landing on the exact cycle where a tick would otherwise hit the limit. In that case the tick must be discarded and must not leave a stray flag or reset pulse. The bench builds this case on purpose. It counts up to a known limit, writes the restart while keeping that limit, and sends a tick in the very next cycle. Random control writes with small limits, and ticks on most cycles, then repeat the collision many times under a cycle-exact model. The alternate path is driven asynchronously while primary pulses keep arriving, which shows that only the selected source is counted.

// File: rtl/cmpwdt_pkg.sv
package cmpwdt_pkg;
  localparam int CNT_W   = 7;
  localparam int SYNC_N  = 2;

  typedef enum logic {
    ACT_IRQ   = 1'b0,
    ACT_RESET = 1'b1
  } match_act_e;
endpackage

// File: rtl/cmpwdt_sync.sv
module cmpwdt_sync #(
  parameter int STAGES = cmpwdt_pkg::SYNC_N
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic rise_pulse
);
  localparam int MSB = STAGES - 1;

  logic [STAGES-1:0] chain;
  logic              last;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[g] <= 1'b0;
          else     chain[g] <= async_in;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[g] <= 1'b0;
          else     chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) last <= 1'b0;
    else     last <= chain[MSB];
  end

  assign rise_pulse = chain[MSB] & ~last;

  AST_ONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    rise_pulse |=> !rise_pulse); // R8
endmodule

// File: rtl/cmpwdt_src.sv
module cmpwdt_src (
  input  logic clk,
  input  logic rst,
  input  logic base_tick,
  input  logic base_clr,
  input  logic alt_pulse,
  input  logic sel_alt,
  output logic tick
);
  logic armed;

  always_ff @(posedge clk) begin
    if (rst)           armed <= 1'b0;
    else if (base_clr) armed <= 1'b1;
  end

  always_comb begin
    if (sel_alt) tick = alt_pulse;
    else         tick = base_tick & armed;
  end

  AST_ARM_STAYS: assert property (@(posedge clk) disable iff (rst)
    armed |=> armed); // R2
endmodule

// File: rtl/cmpwdt_regs.sv
module cmpwdt_regs #(
  parameter int CW = cmpwdt_pkg::CNT_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [CW:0]   wr_data,
  output logic [CW-1:0] limit,
  output logic          clr_pend
);
  localparam logic [CW-1:0] LIMIT_RST = '1;

  always_ff @(posedge clk) begin
    if (rst) begin
      limit    <= LIMIT_RST;
      clr_pend <= 1'b0;
    end else begin
      clr_pend <= wr_en & wr_data[CW];
      if (wr_en) limit <= wr_data[CW-1:0];
    end
  end

  AST_CLR_SELF: assert property (@(posedge clk) disable iff (rst)
    clr_pend && !(wr_en && wr_data[CW]) |=> !clr_pend); // R7
endmodule

// File: rtl/cmpwdt_core.sv
module cmpwdt_core #(
  parameter int CW = cmpwdt_pkg::CNT_W
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   tick,
  input  logic                   clr_pend,
  input  logic [CW-1:0]          limit,
  input  cmpwdt_pkg::match_act_e act,
  input  logic                   irq_clr,
  output logic [CW-1:0]          cnt,
  output logic                   irq_flag,
  output logic                   rst_req
);
  import cmpwdt_pkg::*;

  logic hit;

  assign hit = tick & ~clr_pend & (cnt == limit);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt      <= '0;
      irq_flag <= 1'b0;
      rst_req  <= 1'b0;
    end else begin
      if (clr_pend)  cnt <= '0;
      else if (hit)  cnt <= '0;
      else if (tick) cnt <= cnt + 1'b1;

      rst_req <= hit & (act == ACT_RESET);

      if (hit && act == ACT_IRQ) irq_flag <= 1'b1;
      else if (irq_clr)          irq_flag <= 1'b0;
    end
  end

  AST_CLR_ZERO: assert property (@(posedge clk) disable iff (rst)
    clr_pend |=> cnt == '0); // R7
  AST_HOLD: assert property (@(posedge clk) disable iff (rst)
    !tick && !clr_pend |=> $stable(cnt)); // R3
  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (rst)
    irq_flag && !irq_clr |=> irq_flag); // R5
  AST_RST_CAUSE: assert property (@(posedge clk) disable iff (rst)
    rst_req |-> $past(tick) && $past(act == ACT_RESET)); // R6
  AST_IRQ_MODE: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_flag) |-> $past(act == ACT_IRQ) && $past(tick)); // R5
endmodule

// File: rtl/cmp_watchdog.sv
module cmp_watchdog #(
  parameter int CW    = cmpwdt_pkg::CNT_W,
  parameter int SYNCS = cmpwdt_pkg::SYNC_N
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [CW:0]   wr_data,
  input  logic          act_reset,
  input  logic          base_tick,
  input  logic          base_clr,
  input  logic          alt_tick,
  input  logic          sel_alt,
  input  logic          irq_clr,
  output logic          irq_flag,
  output logic          cpu_rst_req,
  output logic [CW-1:0] count
);
  import cmpwdt_pkg::*;

  logic          alt_pulse;
  logic          tick;
  logic [CW-1:0] limit;
  logic          clr_pend;
  match_act_e    act;

  assign act = act_reset ? ACT_RESET : ACT_IRQ;

  cmpwdt_sync #(.STAGES(SYNCS)) u_sync (
    .clk(clk), .rst(rst), .async_in(alt_tick), .rise_pulse(alt_pulse)
  );

  cmpwdt_src u_src (
    .clk(clk), .rst(rst), .base_tick(base_tick), .base_clr(base_clr),
    .alt_pulse(alt_pulse), .sel_alt(sel_alt), .tick(tick)
  );

  cmpwdt_regs #(.CW(CW)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .limit(limit), .clr_pend(clr_pend)
  );

  cmpwdt_core #(.CW(CW)) u_core (
    .clk(clk), .rst(rst), .tick(tick), .clr_pend(clr_pend), .limit(limit),
    .act(act), .irq_clr(irq_clr), .cnt(count), .irq_flag(irq_flag),
    .rst_req(cpu_rst_req)
  );

  AST_NO_TICK_UNSEL: assert property (@(posedge clk) disable iff (rst)
    !sel_alt && !base_tick && !clr_pend |=> $stable(count)); // R3
endmodule

// File: tb/cmp_watchdog_test.sv
module cmp_watchdog_test;
  localparam int PERIOD = 10;
  localparam int SEED   = 1234;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic       act_reset = 1'b0;
  logic       base_tick = 1'b0;
  logic       base_clr = 1'b0;
  logic       alt_tick = 1'b0;
  logic       sel_alt = 1'b0;
  logic       irq_clr = 1'b0;
  logic       irq_flag;
  logic       cpu_rst_req;
  logic [6:0] count;

  int n_chk = 0;
  int n_fail = 0;

  logic [6:0] m_cnt = '0;
  logic [6:0] m_lim = 7'h7F;
  logic       m_pend = 1'b0;
  logic       m_arm = 1'b0;
  logic       m_irq = 1'b0;
  logic       m_rst = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  cmp_watchdog uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .act_reset(act_reset), .base_tick(base_tick), .base_clr(base_clr),
    .alt_tick(alt_tick), .sel_alt(sel_alt), .irq_clr(irq_clr),
    .irq_flag(irq_flag), .cpu_rst_req(cpu_rst_req), .count(count)
  );

  task automatic chk(input bit ok, input string req, input int act_v, input int exp_v);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual %0d expected %0d", req, act_v, exp_v);
    end
  endtask

  function automatic logic is_hit(input logic tk, input logic pend,
                                  input logic [6:0] c, input logic [6:0] l);
    return tk && !pend && (c == l);
  endfunction

  function automatic logic [6:0] next_cnt(input logic tk, input logic pend,
                                          input logic [6:0] c, input logic [6:0] l);
    if (pend) return '0;
    if (tk) return (c == l) ? 7'd0 : c + 7'd1;
    return c;
  endfunction

  // One primary-source cycle against the model; label names the requirement focus
  task automatic step(input logic tk, input logic bc, input logic w,
                      input logic [7:0] d, input logic ic, input logic ar,
                      input string req);
    logic eff;
    logic hit;
    base_tick = tk; base_clr = bc; wr_en = w; wr_data = d;
    irq_clr = ic; act_reset = ar;
    @(posedge clk);
    eff = tk & m_arm;
    hit = is_hit(eff, m_pend, m_cnt, m_lim);
    m_cnt = next_cnt(eff, m_pend, m_cnt, m_lim);
    m_rst = hit & ar;
    if (hit && !ar) m_irq = 1'b1;
    else if (ic)    m_irq = 1'b0;
    m_pend = w & d[7];
    if (w) m_lim = d[6:0];
    if (bc) m_arm = 1'b1;
    @(negedge clk);
    chk(count == m_cnt, {req, " count"}, int'(count), int'(m_cnt));
    chk(irq_flag == m_irq, {req, " irq_flag"}, int'(irq_flag), int'(m_irq));
    chk(cpu_rst_req == m_rst, {req, " cpu_rst_req"}, int'(cpu_rst_req), int'(m_rst));
  endtask

  initial begin
    #(PERIOD * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog timeout actual 0 expected 1");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(SEED));
    repeat (3) @(negedge clk);
    chk(count == 0, "R1 count in reset", int'(count), 0);
    chk(irq_flag == 0, "R1 irq in reset", int'(irq_flag), 0);
    chk(cpu_rst_req == 0, "R1 rst_req in reset", int'(cpu_rst_req), 0);
    rst = 1'b0;
    @(negedge clk);
    chk(count == 0 && irq_flag == 0 && cpu_rst_req == 0, "R1 after reset", int'(count), 0);

    // R2: ticks before arming are ignored, including the arming cycle itself
    for (int i = 0; i < 6; i++) step(1, 0, 0, 8'h00, 0, 0, "R2 unarmed");
    step(1, 1, 0, 8'h00, 0, 0, "R2 arming cycle");
    chk(count == 0, "R2 arming tick ignored", int'(count), 0);
    step(1, 0, 0, 8'h00, 0, 0, "R2 armed");
    chk(count == 1, "R2 first armed tick", int'(count), 1);

    // R4/R5: limit 4, ticks every cycle, flag on the fifth tick
    step(0, 0, 1, 8'h84, 0, 0, "R7 restart");
    step(0, 0, 0, 8'h00, 0, 0, "R7 restart done");
    chk(count == 0, "R7 count zeroed", int'(count), 0);
    for (int i = 0; i < 5; i++) step(1, 0, 0, 8'h00, 0, 0, "R4 period");
    chk(irq_flag == 1, "R5 flag on match", int'(irq_flag), 1);
    chk(count == 0, "R4 wrap on match", int'(count), 0);
    step(0, 0, 0, 8'h00, 0, 0, "R5 sticky");
    step(0, 0, 0, 8'h00, 1, 0, "R5 clear");
    chk(irq_flag == 0, "R5 cleared", int'(irq_flag), 1'b0);

    // R6: reset mode pulse
    for (int i = 0; i < 5; i++) step(1, 0, 0, 8'h00, 0, 1, "R6 reset mode");
    chk(cpu_rst_req == 1 && irq_flag == 0, "R6 pulse, no flag", int'(cpu_rst_req), 1);
    step(0, 0, 0, 8'h00, 0, 1, "R6 pulse ends");
    chk(cpu_rst_req == 0, "R6 single cycle", int'(cpu_rst_req), 0);

    // R7: restart collides with a tick at the limit
    step(0, 0, 1, 8'h83, 0, 0, "R7 setup");
    for (int i = 0; i < 4; i++) step(1, 0, 0, 8'h00, 0, 0, "R7 count up");
    step(0, 0, 1, 8'h83, 0, 0, "R7 write restart");
    step(1, 0, 0, 8'h00, 0, 0, "R7 collide");
    chk(count == 0 && irq_flag == 0, "R7 tick discarded no match", int'(count), 0);
    step(1, 0, 0, 8'h00, 0, 0, "R7 resumes");
    chk(count == 1, "R7 counts after restart", int'(count), 1);

    // Random mix against the model
    for (int i = 0; i < 3000; i++) begin
      logic w;
      logic [7:0] d;
      w = ($urandom % 16) == 0;
      d = {1'($urandom % 2), 7'($urandom % 9)};
      step(1'(($urandom % 4) != 0), 0, w, d, 1'(($urandom % 8) == 0),
           1'(($urandom % 3) == 0), "R3 R4 R5 R6 R7 random");
    end

    // R8/R3: alternate source, primary pulses ignored while it is selected
    step(0, 0, 1, 8'hFF, 0, 0, "R8 restart");
    step(0, 0, 0, 8'h00, 1, 0, "R8 idle");
    sel_alt = 1'b1;
    for (int k = 0; k < 5; k++) begin
      alt_tick = 1'b1;
      repeat (4) begin base_tick = 1'b1; @(negedge clk); end
      alt_tick = 1'b0;
      repeat (4) begin base_tick = 1'b0; @(negedge clk); end
    end
    chk(count == 5, "R8 one count per alternate rise", int'(count), 5);
    alt_tick = 1'b1;
    @(negedge clk); @(negedge clk);
    chk(count == 5, "R8 latency not yet", int'(count), 5);
    @(negedge clk);
    chk(count == 6, "R8 third edge", int'(count), 6);
    alt_tick = 1'b0;
    repeat (3) @(negedge clk);
    sel_alt = 1'b0;
    m_cnt = 7'd6; m_lim = 7'h7F; m_irq = 1'b0; m_rst = 1'b0;
    step(1, 0, 0, 8'h00, 0, 0, "R3 back to primary");
    chk(count == 7, "R3 primary resumes", int'(count), 7);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule